// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits on the processor side of the interrupt path. It decides at each instruction boundary whether an interrupt is taken. When one is taken, it runs the bus sequence that saves the interrupted context and loads the handler address. When the core executes a return-from-interrupt, it restores that context. It owns the flags word, the code segment, the instruction pointer and the stack pointer. The core reaches them only through a flags write strobe, the next-instruction pointer given at each boundary, and the return request.

There are four request sources:

- a level-sensitive maskable line, gated by the interrupt-enable flag;
- a non-maskable line that must rise and then stay high for a programmable number of cycles;
- a single-step condition taken from the trap flag;
- a software request that carries its own type byte.

A maskable request is answered with two active-low acknowledge pulses. The device's type byte is taken from the data bus after the second pulse. All stack and vector-table traffic uses one request/acknowledge memory port. Physical addresses are formed as segment shifted left by four plus offset. While a sequence is running, `busy` is high and the core must hold instruction execution.

Top module: `intr_seq`

## Requirements
- R1: A maskable request is accepted only in a cycle where `instr_end` is high and flags bit 9 (interrupt enable) is 1. With that bit 0, or with no boundary strobe, it is ignored: no bus activity, and CS and IP keep their values.
- R2: The non-maskable line is qualified when it rises from low and is then sampled high for NMI_HOLD consecutive cycles (default 2). A qualified event stays pending until the next boundary takes it. It enters with type 2 whatever the value of flags bit 9. A pulse that is shorter is ignored.
- R3: A maskable entry drives `ack_n` low for ACK_W cycles, high for GAP_W cycles, and low again for ACK_W cycles. The type byte on `data_in` is captured in the first cycle after the second pulse ends.
- R4: Entry pushes three words in this order: the flags as they were before entry, then CS, then the IP. Before each push the stack pointer is lowered by 2, and the word is written at SS*16+SP. Once the flags push completes, flags bit 9 and bit 8 (trap) are cleared.
- R5: For type N, entry reads the new IP from physical address N*4 and the new CS from N*4+2. It then loads both.
- R6: On `ret_req` the block reads the IP, then CS, then the flags from SS*16+SP. SP is raised by 2 after each read.
- R7: When flags bit 8 is 1 at a boundary and nothing else is pending, type 1 is entered. A software request enters with `sw_type`. Neither of these produces acknowledge pulses.
- R8: When requests coincide at a boundary, the winner is chosen in this order: non-maskable, software, maskable, single-step.
- R9: `busy` goes high in the cycle after an accepted boundary or return request. It stays high until CS:IP has been loaded. While it is high, boundary strobes and requests are ignored. `ack_n` pulses and memory requests occur only while `busy` is high.
- R10: The IP register takes `next_ip` at every boundary strobe while idle. The IP pushed on entry is the `next_ip` of the accepting boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_end | input | 1 | Last cycle of an instruction |
| next_ip | input | DW | Pointer of the next instruction, valid with `instr_end` |
| ret_req | input | 1 | Start the return sequence |
| flags_wr | input | 1 | Write the flags word while idle |
| flags_wdata | input | DW | Flags value to write |
| mask_req | input | 1 | Maskable request, level, active high |
| nmi_in | input | 1 | Non-maskable request line |
| sw_req | input | 1 | Software interrupt request, sampled at a boundary |
| sw_type | input | TW | Type byte of the software request |
| ack_n | output | 1 | Acknowledge pulses, active low |
| data_in | input | TW | Type byte from the interrupting device |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | 1 = stack write, 0 = read |
| mem_addr | output | AW | Physical byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current memory operation |
| ss_in | input | DW | Stack segment |
| busy | output | 1 | Sequence in progress; execution must hold |
| cur_cs | output | DW | Code segment register |
| cur_ip | output | DW | Instruction pointer register |
| cur_sp | output | DW | Stack pointer register |
| cur_flags | output | DW | Flags register |

## Verification
The assertions check several invariants on every cycle:

- acknowledge pulses and memory traffic never occur outside `busy`, and never overlap each other;
- each completed push lowers SP by two, and each completed pop raises it by two;
- the offset read of the vector table is aligned and lies inside the table;
- both enable and trap flags are clear once the segment word is loaded.

Only the bench's scenarios can show the end-to-end behaviour: the ordering among coincident requests, the stacked words and their addresses, the captured type byte, the acknowledge pulse width, the rejection of short non-maskable pulses, and the exact restoration of the context on return.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ACK,
      ST_PUSH_FL,
      ST_PUSH_CS,
      ST_PUSH_IP,
      ST_RD_OFF,
      ST_RD_SEG,
      ST_POP_IP,
      ST_POP_CS,
      ST_POP_FL
   } seq_state_e;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_NMI,
      SRC_SW,
      SRC_MASK,
      SRC_STEP
   } req_src_e;

   localparam int unsigned FLAG_IF = 9;
   localparam int unsigned FLAG_TF = 8;

endpackage

// File: rtl/intr_nmi_qual.sv
module intr_nmi_qual #(
   parameter int unsigned HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic take,
   output logic pend
);

   logic prev_q;
   logic fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= nmi_in;
   end

   generate
      if (HOLD <= 1) begin : g_edge
         assign fire = nmi_in & ~prev_q;
      end else begin : g_hold
         localparam int unsigned CW = $clog2(HOLD + 1);
         logic [CW-1:0] run_q;
         logic [CW-1:0] run_d;

         always_comb begin
            if (!nmi_in)
               run_d = '0;
            else if (!prev_q)
               run_d = CW'(1);
            else if (run_q != '0 && run_q != CW'(HOLD))
               run_d = run_q + CW'(1);
            else
               run_d = run_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) run_q <= '0;
            else        run_q <= run_d;
         end

         assign fire = (run_d == CW'(HOLD)) && (run_q != CW'(HOLD));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= fire | (pend & ~take);
   end

endmodule

// File: rtl/intr_ack_pulser.sv
module intr_ack_pulser #(
   parameter int unsigned ACK_W = 2,
   parameter int unsigned GAP_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ack_n,
   output logic done
);

   localparam int unsigned MAXW = (ACK_W > GAP_W) ? ACK_W : GAP_W;
   localparam int unsigned CW   = $clog2(MAXW + 1);

   typedef enum logic [1:0] {PH_IDLE, PH_LOW1, PH_GAP, PH_LOW2} ph_e;

   ph_e           ph_q;
   logic [CW-1:0] cnt_q;
   logic          fin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q  <= PH_LOW1;
                  cnt_q <= '0;
               end
            end
            PH_LOW1: begin
               if (cnt_q == CW'(ACK_W - 1)) begin
                  ph_q  <= PH_GAP;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            PH_GAP: begin
               if (cnt_q == CW'(GAP_W - 1)) begin
                  ph_q  <= PH_LOW2;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            PH_LOW2: begin
               if (cnt_q == CW'(ACK_W - 1)) begin
                  ph_q  <= PH_IDLE;
                  cnt_q <= '0;
                  fin_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign ack_n = !((ph_q == PH_LOW1) || (ph_q == PH_LOW2));
   assign done  = fin_q;

endmodule

// File: rtl/intr_req_arb.sv
module intr_req_arb
   import intr_seq_pkg::*;
#(
   parameter int unsigned    TW        = 8,
   parameter logic [TW-1:0]  NMI_TYPE  = TW'(2),
   parameter logic [TW-1:0]  STEP_TYPE = TW'(1)
) (
   input  logic          nmi_pend,
   input  logic          sw_req,
   input  logic [TW-1:0] sw_type,
   input  logic          mask_req,
   input  logic          if_flag,
   input  logic          tf_flag,
   output req_src_e      src,
   output logic [TW-1:0] vtype
);

   always_comb begin
      src   = SRC_NONE;
      vtype = '0;
      if (nmi_pend) begin
         src   = SRC_NMI;
         vtype = NMI_TYPE;
      end else if (sw_req) begin
         src   = SRC_SW;
         vtype = sw_type;
      end else if (mask_req && if_flag) begin
         src   = SRC_MASK;
         vtype = '0;
      end else if (tf_flag) begin
         src   = SRC_STEP;
         vtype = STEP_TYPE;
      end
   end

endmodule

// File: rtl/intr_seq.sv
module intr_seq
   import intr_seq_pkg::*;
#(
   parameter int unsigned    DW        = 16,
   parameter int unsigned    AW        = 20,
   parameter int unsigned    TW        = 8,
   parameter int unsigned    SEG_SHIFT = 4,
   parameter int unsigned    ACK_W     = 2,
   parameter int unsigned    GAP_W     = 2,
   parameter int unsigned    NMI_HOLD  = 2,
   parameter logic [DW-1:0]  RST_CS    = 16'hF000,
   parameter logic [DW-1:0]  RST_IP    = 16'h0000,
   parameter logic [DW-1:0]  RST_SP    = 16'h0800,
   parameter logic [DW-1:0]  RST_FLAGS = 16'h0002
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          instr_end,
   input  logic [DW-1:0] next_ip,
   input  logic          ret_req,
   input  logic          flags_wr,
   input  logic [DW-1:0] flags_wdata,
   input  logic          mask_req,
   input  logic          nmi_in,
   input  logic          sw_req,
   input  logic [TW-1:0] sw_type,
   output logic          ack_n,
   input  logic [TW-1:0] data_in,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] ss_in,
   output logic          busy,
   output logic [DW-1:0] cur_cs,
   output logic [DW-1:0] cur_ip,
   output logic [DW-1:0] cur_sp,
   output logic [DW-1:0] cur_flags
);

   localparam int unsigned WORD_BYTES = DW / 8;
   localparam int unsigned VEC_BYTES  = 2 * WORD_BYTES;
   localparam int unsigned VEC_SHIFT  = $clog2(VEC_BYTES);

   generate
      if (DW % 8 != 0) begin : g_bad_dw
         $error("intr_seq: DW must be a whole number of bytes");
      end
      if (DW <= FLAG_IF) begin : g_bad_flags
         $error("intr_seq: DW too narrow for the flag positions");
      end
      if (AW < TW + VEC_SHIFT) begin : g_bad_aw
         $error("intr_seq: AW cannot hold the vector table");
      end
      if (ACK_W < 1 || GAP_W < 1 || NMI_HOLD < 1) begin : g_bad_w
         $error("intr_seq: pulse widths and hold must be at least 1");
      end
   endgenerate

   seq_state_e    state_q;
   logic [DW-1:0] cs_q, ip_q, sp_q, fl_q, ip_new_q;
   logic [TW-1:0] vtype_q;

   req_src_e      arb_src;
   logic [TW-1:0] arb_type;
   logic          nmi_pend;
   logic          ack_done;
   logic          idle;
   logic          take_irq;
   logic [DW-1:0] sp_dn, sp_up;
   logic [AW-1:0] vec_off, vec_seg;

   function automatic logic [AW-1:0] phys(input logic [DW-1:0] seg, input logic [DW-1:0] off);
      return (AW'(seg) << SEG_SHIFT) + AW'(off);
   endfunction

   assign idle     = (state_q == ST_IDLE);
   assign take_irq = idle && instr_end && !ret_req && (arb_src != SRC_NONE);
   assign sp_dn    = sp_q - DW'(WORD_BYTES);
   assign sp_up    = sp_q + DW'(WORD_BYTES);
   assign vec_off  = AW'({vtype_q, {VEC_SHIFT{1'b0}}});
   assign vec_seg  = vec_off + AW'(WORD_BYTES);

   intr_nmi_qual #(.HOLD(NMI_HOLD)) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .nmi_in (nmi_in),
      .take   (take_irq && (arb_src == SRC_NMI)),
      .pend   (nmi_pend)
   );

   intr_req_arb #(.TW(TW)) u_arb (
      .nmi_pend (nmi_pend),
      .sw_req   (sw_req),
      .sw_type  (sw_type),
      .mask_req (mask_req),
      .if_flag  (fl_q[FLAG_IF]),
      .tf_flag  (fl_q[FLAG_TF]),
      .src      (arb_src),
      .vtype    (arb_type)
   );

   intr_ack_pulser #(.ACK_W(ACK_W), .GAP_W(GAP_W)) u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .start (take_irq && (arb_src == SRC_MASK)),
      .ack_n (ack_n),
      .done  (ack_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cs_q     <= RST_CS;
         ip_q     <= RST_IP;
         sp_q     <= RST_SP;
         fl_q     <= RST_FLAGS;
         vtype_q  <= '0;
         ip_new_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (flags_wr) fl_q <= flags_wdata;
               if (instr_end) ip_q <= next_ip;
               if (ret_req) begin
                  state_q <= ST_POP_IP;
               end else if (take_irq) begin
                  vtype_q <= arb_type;
                  state_q <= (arb_src == SRC_MASK) ? ST_ACK : ST_PUSH_FL;
               end
            end
            ST_ACK: begin
               if (ack_done) begin
                  vtype_q <= data_in;
                  state_q <= ST_PUSH_FL;
               end
            end
            ST_PUSH_FL: begin
               if (mem_ack) begin
                  sp_q          <= sp_dn;
                  fl_q[FLAG_IF] <= 1'b0;
                  fl_q[FLAG_TF] <= 1'b0;
                  state_q       <= ST_PUSH_CS;
               end
            end
            ST_PUSH_CS: begin
               if (mem_ack) begin
                  sp_q    <= sp_dn;
                  state_q <= ST_PUSH_IP;
               end
            end
            ST_PUSH_IP: begin
               if (mem_ack) begin
                  sp_q    <= sp_dn;
                  state_q <= ST_RD_OFF;
               end
            end
            ST_RD_OFF: begin
               if (mem_ack) begin
                  ip_new_q <= mem_rdata;
                  state_q  <= ST_RD_SEG;
               end
            end
            ST_RD_SEG: begin
               if (mem_ack) begin
                  cs_q    <= mem_rdata;
                  ip_q    <= ip_new_q;
                  state_q <= ST_IDLE;
               end
            end
            ST_POP_IP: begin
               if (mem_ack) begin
                  ip_q    <= mem_rdata;
                  sp_q    <= sp_up;
                  state_q <= ST_POP_CS;
               end
            end
            ST_POP_CS: begin
               if (mem_ack) begin
                  cs_q    <= mem_rdata;
                  sp_q    <= sp_up;
                  state_q <= ST_POP_FL;
               end
            end
            ST_POP_FL: begin
               if (mem_ack) begin
                  fl_q    <= mem_rdata;
                  sp_q    <= sp_up;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state_q)
         ST_PUSH_FL: begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = phys(ss_in, sp_dn); mem_wdata = fl_q;
         end
         ST_PUSH_CS: begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = phys(ss_in, sp_dn); mem_wdata = cs_q;
         end
         ST_PUSH_IP: begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = phys(ss_in, sp_dn); mem_wdata = ip_q;
         end
         ST_RD_OFF: begin
            mem_req = 1'b1; mem_addr = vec_off;
         end
         ST_RD_SEG: begin
            mem_req = 1'b1; mem_addr = vec_seg;
         end
         ST_POP_IP, ST_POP_CS, ST_POP_FL: begin
            mem_req = 1'b1; mem_addr = phys(ss_in, sp_q);
         end
         default: begin
            mem_req = 1'b0;
         end
      endcase
   end

   assign busy      = !idle;
   assign cur_cs    = cs_q;
   assign cur_ip    = ip_q;
   assign cur_sp    = sp_q;
   assign cur_flags = fl_q;

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk
   import intr_seq_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 20,
   parameter int unsigned TW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          ack_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] cur_sp,
   input logic [DW-1:0] cur_flags,
   input seq_state_e    st
);

   // R9: acknowledge pulses only during a sequence
   assert_ack_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> busy);

   // R9: memory traffic only during a sequence
   assert_mem_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R3: type fetch and memory traffic never overlap
   assert_ack_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> !mem_req);

   // R4: each completed push lowers the stack pointer by one word
   assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (cur_sp == $past(cur_sp) - DW'(2)));

   // R6: each completed pop raises the stack pointer by one word
   assert_pop_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && (st == ST_POP_IP || st == ST_POP_CS || st == ST_POP_FL))
      |=> (cur_sp == $past(cur_sp) + DW'(2)));

   // R5: offset read is aligned and inside the vector table
   assert_vec_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD_OFF && mem_req) |-> ((mem_addr[1:0] == 2'b00) && ((mem_addr >> (TW + 2)) == '0)));

   // R4: enable and trap flags clear once entry completes
   assert_flags_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD_SEG && mem_ack) |=> (!cur_flags[FLAG_IF] && !cur_flags[FLAG_TF]));

endmodule

bind intr_seq intr_seq_chk #(.DW(DW), .AW(AW), .TW(TW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .ack_n     (ack_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .cur_sp    (cur_sp),
   .cur_flags (cur_flags),
   .st        (state_q)
);

// File: tb/intr_seq_bench.sv
module intr_seq_bench;

   localparam int          ACK_W     = 2;
   localparam logic [15:0] RST_SP    = 16'h0800;
   localparam logic [15:0] RST_CS    = 16'hF000;
   localparam logic [15:0] RST_FLAGS = 16'h0002;
   localparam logic [15:0] SS        = 16'h0200;

   // req bits: [2] non-maskable, [1] software, [0] maskable
   typedef struct packed {
      logic [2:0] req;
      logic       ifb;
      logic       tfb;
      logic [7:0] swt;
      logic [7:0] devt;
      logic [7:0] expt;
      logic [1:0] acks;
      logic       taken;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{3'b001, 1'b1, 1'b0, 8'h00, 8'h08, 8'h08, 2'd2, 1'b1},
      '{3'b001, 1'b1, 1'b0, 8'h00, 8'h4D, 8'h4D, 2'd2, 1'b1},
      '{3'b001, 1'b0, 1'b0, 8'h00, 8'h4D, 8'h00, 2'd0, 1'b0},
      '{3'b010, 1'b0, 1'b0, 8'h21, 8'h00, 8'h21, 2'd0, 1'b1},
      '{3'b100, 1'b0, 1'b0, 8'h00, 8'h00, 8'h02, 2'd0, 1'b1},
      '{3'b000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h01, 2'd0, 1'b1},
      '{3'b010, 1'b1, 1'b0, 8'hFF, 8'h00, 8'hFF, 2'd0, 1'b1},
      '{3'b111, 1'b1, 1'b1, 8'h40, 8'h41, 8'h02, 2'd0, 1'b1},
      '{3'b011, 1'b1, 1'b1, 8'h33, 8'h44, 8'h33, 2'd0, 1'b1},
      '{3'b001, 1'b1, 1'b1, 8'h00, 8'h55, 8'h55, 2'd2, 1'b1},
      '{3'b001, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd2, 1'b1},
      '{3'b000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'd0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_end = 1'b0;
   logic [15:0] next_ip = '0;
   logic        ret_req = 1'b0;
   logic        flags_wr = 1'b0;
   logic [15:0] flags_wdata = '0;
   logic        mask_req = 1'b0;
   logic        nmi_in = 1'b0;
   logic        sw_req = 1'b0;
   logic [7:0]  sw_type = '0;
   logic        ack_n;
   logic [7:0]  data_in = '0;
   logic        mem_req, mem_we;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        busy;
   logic [15:0] cur_cs, cur_ip, cur_sp, cur_flags;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [15:0] smem [int];
   logic [19:0] wa [8];
   logic [15:0] wd [8];
   logic [19:0] ra [8];
   int          wn = 0;
   int          rn = 0;
   int          ack_falls = 0;
   int          lowrun = 0;
   int          last_low = 0;
   logic        ack_prev = 1'b1;
   logic [7:0]  dev_t = '0;

   always #5 clk = ~clk;

   intr_seq u_intr_seq (
      .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .next_ip(next_ip),
      .ret_req(ret_req), .flags_wr(flags_wr), .flags_wdata(flags_wdata),
      .mask_req(mask_req), .nmi_in(nmi_in), .sw_req(sw_req), .sw_type(sw_type),
      .ack_n(ack_n), .data_in(data_in), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .ss_in(SS), .busy(busy), .cur_cs(cur_cs),
      .cur_ip(cur_ip), .cur_sp(cur_sp), .cur_flags(cur_flags)
   );

   function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
      return ({4'h0, s} << 4) + {4'h0, o};
   endfunction

   function automatic logic [15:0] rd_model(input logic [19:0] a);
      if (a < 20'd1024)
         return a[1] ? {8'hC0, a[9:2]} : {8'hA0, a[9:2]};
      else if (smem.exists(int'(a)))
         return smem[int'(a)];
      else
         return 16'hDEAD;
   endfunction

   // memory responder: one operation every two cycles
   always @(negedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack = 1'b1;
         if (mem_we) begin
            smem[int'(mem_addr)] = mem_wdata;
            if (wn < 8) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
            wn++;
         end else begin
            mem_rdata = rd_model(mem_addr);
            if (rn < 8) ra[rn] = mem_addr;
            rn++;
         end
      end else begin
         mem_ack = 1'b0;
      end
   end

   // device model: counts acknowledge pulses, offers the type after the second
   always @(negedge clk) begin
      if (!ack_n) begin
         if (ack_prev) ack_falls++;
         lowrun++;
      end else begin
         if (!ack_prev) last_low = lowrun;
         lowrun = 0;
      end
      ack_prev = ack_n;
      data_in  = (ack_falls >= 2) ? dev_t : ~dev_t;
   end

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 300) begin
         @(negedge clk);
         n++;
      end
      if (n >= 300) chk(1'b0, "R9 busy never cleared", 32'(busy), 32'd0);
   endtask

   task automatic set_flags(input logic [15:0] f);
      flags_wr = 1'b1; flags_wdata = f;
      @(negedge clk);
      flags_wr = 1'b0;
   endtask

   task automatic nmi_pulse(input int len);
      nmi_in = 1'b1;
      repeat (len) @(negedge clk);
      nmi_in = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_return(input logic [15:0] nip, input logic [15:0] cs0,
                            input logic [15:0] fl, input logic [15:0] sp0);
      wn = 0; rn = 0;
      ret_req = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
      chk(busy == 1'b1, "R9 busy after return request", 32'(busy), 32'd1);
      wait_idle();
      chk(cur_ip == nip, "R6 IP restored", 32'(cur_ip), 32'(nip));
      chk(cur_cs == cs0, "R6 CS restored", 32'(cur_cs), 32'(cs0));
      chk(cur_flags == fl, "R6 flags restored", 32'(cur_flags), 32'(fl));
      chk(cur_sp == sp0, "R6 SP restored", 32'(cur_sp), 32'(sp0));
      chk(rn == 3 && ra[0] == phys(SS, sp0 - 16'd6) && ra[1] == phys(SS, sp0 - 16'd4)
          && ra[2] == phys(SS, sp0 - 16'd2), "R6 pop order", 32'(ra[0]), 32'(phys(SS, sp0 - 16'd6)));
   endtask

   task automatic run_vec(input int i);
      vec_t        v;
      logic [15:0] fl, nip, cs0, sp0;
      v   = VECS[i];
      fl  = {6'b0, v.ifb, v.tfb, 8'h02};
      nip = 16'h1000 + 16'(i * 16);
      set_flags(fl);
      if (v.req[2]) nmi_pulse(2);
      dev_t = v.devt; ack_falls = 0; last_low = 0; wn = 0; rn = 0;
      cs0 = cur_cs; sp0 = cur_sp;
      mask_req = v.req[0]; sw_req = v.req[1]; sw_type = v.swt;
      next_ip = nip; instr_end = 1'b1;
      @(negedge clk);
      instr_end = 1'b0; sw_req = 1'b0; mask_req = 1'b0;
      chk(busy == v.taken, "R9 busy in cycle after boundary", 32'(busy), 32'(v.taken));
      wait_idle();
      if (v.taken) begin
         // R5 / R8 / R2 / R7: loaded vector identifies the chosen type
         chk(cur_ip == {8'hA0, v.expt}, "R5 R8 new IP from N*4", 32'(cur_ip), 32'({8'hA0, v.expt}));
         chk(cur_cs == {8'hC0, v.expt}, "R5 R8 new CS from N*4+2", 32'(cur_cs), 32'({8'hC0, v.expt}));
         chk(rn == 2 && ra[0] == 20'(v.expt) * 4 && ra[1] == 20'(v.expt) * 4 + 2,
             "R5 vector read addresses", 32'(ra[0]), 32'(20'(v.expt) * 4));
         chk(wn == 3 && wa[0] == phys(SS, sp0 - 16'd2) && wa[1] == phys(SS, sp0 - 16'd4)
             && wa[2] == phys(SS, sp0 - 16'd6), "R4 push addresses", 32'(wa[0]), 32'(phys(SS, sp0 - 16'd2)));
         chk(wd[0] == fl && wd[1] == cs0, "R4 pushed flags then CS", 32'({wd[0], wd[1]}), 32'({fl, cs0}));
         chk(wd[2] == nip, "R10 pushed IP is next_ip", 32'(wd[2]), 32'(nip));
         chk(cur_flags[9] == 1'b0 && cur_flags[8] == 1'b0, "R4 IF and TF cleared",
             32'(cur_flags), 32'(fl & 16'hFCFF));
         chk(cur_sp == sp0 - 16'd6, "R4 SP after entry", 32'(cur_sp), 32'(sp0 - 16'd6));
         chk(ack_falls == int'(v.acks), "R3 R7 acknowledge pulse count", 32'(ack_falls), 32'(v.acks));
         if (v.acks == 2)
            chk(last_low == ACK_W, "R3 acknowledge pulse width", 32'(last_low), 32'(ACK_W));
         do_return(nip, cs0, fl, sp0);
      end else begin
         chk(cur_cs == cs0 && wn == 0 && rn == 0, "R1 request ignored", 32'(cur_cs), 32'(cs0));
         chk(cur_ip == nip, "R10 IP follows next_ip", 32'(cur_ip), 32'(nip));
         chk(ack_falls == 0, "R1 no acknowledge", 32'(ack_falls), 32'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk(busy == 1'b0 && ack_n == 1'b1 && mem_req == 1'b0, "R9 reset outputs idle",
          32'({busy, ack_n, mem_req}), 32'b010);
      chk(cur_sp == RST_SP && cur_cs == RST_CS && cur_ip == 16'h0 && cur_flags == RST_FLAGS,
          "R4 reset registers", 32'(cur_sp), 32'(RST_SP));
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(i);

      // R2: a one-cycle non-maskable pulse is not qualified
      begin
         logic [15:0] cs0;
         set_flags(16'h0002);
         nmi_pulse(1);
         repeat (2) @(negedge clk);
         cs0 = cur_cs; wn = 0;
         next_ip = 16'h2222; instr_end = 1'b1;
         @(negedge clk);
         instr_end = 1'b0;
         chk(busy == 1'b0, "R2 short pulse ignored", 32'(busy), 32'd0);
         repeat (3) @(negedge clk);
         chk(cur_cs == cs0 && wn == 0, "R2 no entry after short pulse", 32'(wn), 32'd0);
      end

      // R1: maskable request without a boundary strobe is not taken
      begin
         int seen = 0;
         set_flags(16'h0202);
         mask_req = 1'b1;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (busy) seen++;
         end
         mask_req = 1'b0;
         chk(seen == 0, "R1 no boundary, no entry", 32'(seen), 32'd0);
      end

      // R9: a boundary with a request during a running sequence is ignored
      begin
         logic [15:0] cs0, sp0, nip;
         set_flags(16'h0002);
         cs0 = cur_cs; sp0 = cur_sp; nip = 16'h3300; wn = 0; rn = 0;
         sw_req = 1'b1; sw_type = 8'h10; next_ip = nip; instr_end = 1'b1;
         @(negedge clk);
         sw_type = 8'h77; next_ip = 16'h4400;
         @(negedge clk);
         instr_end = 1'b0; sw_req = 1'b0;
         wait_idle();
         chk(cur_cs == 16'hC010 && cur_ip == 16'hA010, "R9 second boundary ignored",
             32'(cur_cs), 32'hC010);
         chk(wn == 3 && wd[2] == nip, "R9 R10 pushed IP of accepted boundary", 32'(wd[2]), 32'(nip));
         repeat (3) @(negedge clk);
         chk(busy == 1'b0, "R9 no second entry", 32'(busy), 32'd0);
         do_return(nip, cs0, 16'h0002, sp0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL R9 watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule